// File: doc/BRIEF.md
# Multiprocessor-Mode Serial Receiver

This block is an asynchronous serial receiver for a shared line where several stations listen to one sender. Every frame carries one extra bit beside its eight data bits. That bit marks the frame as a station-ID frame (1) or as a data frame (0). A station that does not yet know whether the traffic is meant for it sets its ID-wait bit. While that bit is set, the receiver drops every data frame and delivers only the next ID frame. Host software then compares the delivered ID with its own. On a mismatch the host sets ID-wait again and clears data-ready. On a match it only clears data-ready and goes on to read the data frames that follow.

The input is sampled 16 times per bit from a simple clock divider. A start bit must still be low at its mid-point before a frame begins. Data-ready, overrun and framing-error flags each have their own clear input. While either error flag is set, no new frame is taken in. The synchronized line level is also brought out, so that software can tell a held-low break from a single bad frame.

Top module: `mpx_serial_rx`

## Requirements
- R1: A frame is a low start bit, 8 data bits sent LSB first, one marker bit and a high stop bit. Each bit lasts OVS*CLK_DIV clocks and is sampled at mid-bit. An accepted frame loads its 8 data bits into `rdata` and sets `dready` to 1.
- R2: A low pulse on `rxd` shorter than half a bit time does not start a frame. A correct frame that follows the pulse is received correctly.
- R3: While `idwait` is 1, a frame whose marker bit is 0 is discarded. `rdata`, `dready`, `ovr`, `ferr` and `idwait` all stay unchanged.
- R4: While `idwait` is 1, a frame whose marker bit is 1 is accepted as in R1, and the hardware clears `idwait` to 0 in the same cycle.
- R5: A one-cycle pulse on `idwait_set` sets `idwait` to 1. While `idwait` is 0, frames are accepted whatever their marker bit.
- R6: A good frame that completes while `dready` is 1 sets `ovr` to 1. `rdata` keeps its old value.
- R7: A frame whose stop bit is sampled as 0 sets `ferr` to 1. `rdata` and `dready` stay unchanged.
- R8: While `ovr` or `ferr` is 1, no frame is received. Once both flags are cleared, reception resumes.
- R9: A one-cycle pulse on `dready_clr`, `ovr_clr` or `ferr_clr` clears its own flag on the next clock edge.
- R10: `rxd_level` shows `rxd` through a two-stage synchronizer, so it follows the pin two clock edges later.
- R11: While `rx_en` is 0, nothing is received. Dropping `rx_en` in the middle of a frame discards that frame.
- R12: After reset, `rdata` is 0 and `dready`, `ovr`, `ferr` and `idwait` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Receive enable |
| idwait_set | input | 1 | Pulse that sets the ID-wait bit |
| dready_clr | input | 1 | Pulse that clears data-ready |
| ovr_clr | input | 1 | Pulse that clears the overrun flag |
| ferr_clr | input | 1 | Pulse that clears the framing-error flag |
| rxd_level | output | 1 | Synchronized level of rxd |
| idwait | output | 1 | ID-wait bit |
| dready | output | 1 | Data-ready flag |
| ovr | output | 1 | Overrun flag |
| ferr | output | 1 | Framing-error flag |
| rdata | output | DATA_W | Receive data register |

## Verification
The checker watches the flag rules on every cycle. An overrun or framing error never changes `rdata`. Accepting a frame while ID-wait is set always drops ID-wait. No frame lands while an error flag is set or while the receiver is disabled. A data-ready clear always takes effect. Other behaviour can only be shown by the bench scenarios, because it needs real serial waveforms and known expected bytes. This covers LSB-first bit order, mid-bit sampling, rejection of a short start glitch, the discarding of data frames during ID-wait, and the full ID-mismatch and ID-match host sequences.

// File: rtl/mpx_rx_pkg.sv
package mpx_rx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_t;
endpackage

// File: rtl/mpx_tick_gen.sv
module mpx_tick_gen #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

   logic [DIV_W-1:0] div_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  div_cnt <= '0;
      else if (restart || tick)    div_cnt <= '0;
      else                         div_cnt <= div_cnt + 1'b1;
   end

   assign tick = !restart && (div_cnt == DIV_LAST);
endmodule

// File: rtl/mpx_frame_rx.sv
module mpx_frame_rx
   import mpx_rx_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              block,
   input  logic              line,
   input  logic              tick,
   output logic              restart,
   output logic              done,
   output logic              stop_ok,
   output logic [DATA_W:0]   frame_bits
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W + 2);
   localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W);

   rx_state_t        state;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] idx;
   logic [DATA_W:0]  shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         cnt   <= '0;
         idx   <= '0;
         shreg <= '0;
      end else if (!en) begin
         state <= RX_IDLE;
      end else begin
         unique case (state)
            RX_IDLE: begin
               cnt <= '0;
               idx <= '0;
               if (!block && !line) state <= RX_START;
            end
            RX_START: if (tick) begin
               if (cnt == MID_CNT) begin
                  cnt   <= '0;
                  state <= line ? RX_IDLE : RX_BITS;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_BITS: if (tick) begin
               if (cnt == LAST_CNT) begin
                  cnt   <= '0;
                  shreg <= {line, shreg[DATA_W:1]};
                  if (idx == LAST_IDX) state <= RX_STOP;
                  else                 idx   <= idx + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_STOP: if (tick) begin
               if (cnt == LAST_CNT) state <= RX_IDLE;
               else                 cnt   <= cnt + 1'b1;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   assign restart    = (state == RX_IDLE);
   assign done       = en && (state == RX_STOP) && tick && (cnt == LAST_CNT);
   assign stop_ok    = line;
   assign frame_bits = shreg;
endmodule

// File: rtl/mpx_status.sv
module mpx_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic              stop_ok,
   input  logic [DATA_W:0]   frame_bits,
   input  logic              idwait_set,
   input  logic              dready_clr,
   input  logic              ovr_clr,
   input  logic              ferr_clr,
   output logic              idwait,
   output logic              dready,
   output logic              ovr,
   output logic              ferr,
   output logic [DATA_W-1:0] rdata
);
   logic is_id, good, skip, over, take;

   always_comb begin
      is_id = frame_bits[DATA_W];
      good  = done && stop_ok;
      skip  = good && idwait && !is_id;
      over  = good && !skip && dready;
      take  = good && !skip && !dready;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idwait <= 1'b0;
         dready <= 1'b0;
         ovr    <= 1'b0;
         ferr   <= 1'b0;
         rdata  <= '0;
      end else begin
         if (take) rdata <= frame_bits[DATA_W-1:0];
         dready <= take | (dready & ~dready_clr);
         ovr    <= over | (ovr & ~ovr_clr);
         ferr   <= (done && !stop_ok) | (ferr & ~ferr_clr);
         idwait <= idwait_set | (idwait & ~(take & is_id));
      end
   end
endmodule

// File: rtl/mpx_serial_rx.sv
module mpx_serial_rx #(
   parameter int CLK_DIV     = 4,
   parameter int OVS         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   input  logic              rx_en,
   input  logic              idwait_set,
   input  logic              dready_clr,
   input  logic              ovr_clr,
   input  logic              ferr_clr,
   output logic              rxd_level,
   output logic              idwait,
   output logic              dready,
   output logic              ovr,
   output logic              ferr,
   output logic [DATA_W-1:0] rdata
);
   generate
      if (CLK_DIV < 2)            begin : g_bad_div  $error("CLK_DIV must be at least 2"); end
      if (OVS < 4 || OVS % 2 != 0) begin : g_bad_ovs  $error("OVS must be even and at least 4"); end
      if (DATA_W < 1)             begin : g_bad_w    $error("DATA_W must be positive"); end
      if (SYNC_STAGES < 0)        begin : g_bad_sync $error("SYNC_STAGES must not be negative"); end
   endgenerate

   logic line_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign line_s = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[i] <= 1'b1;
               else        sync_q[i] <= (i == 0) ? rxd : sync_q[(i == 0) ? 0 : i - 1];
            end
         end
         assign line_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   logic restart, tick, done, stop_ok;
   logic [DATA_W:0] frame_bits;

   mpx_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
   );

   mpx_frame_rx #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .block(ovr | ferr),
      .line(line_s), .tick(tick), .restart(restart), .done(done),
      .stop_ok(stop_ok), .frame_bits(frame_bits)
   );

   mpx_status #(.DATA_W(DATA_W)) u_status (
      .clk(clk), .rst_n(rst_n), .done(done), .stop_ok(stop_ok),
      .frame_bits(frame_bits), .idwait_set(idwait_set),
      .dready_clr(dready_clr), .ovr_clr(ovr_clr), .ferr_clr(ferr_clr),
      .idwait(idwait), .dready(dready), .ovr(ovr), .ferr(ferr), .rdata(rdata)
   );

   assign rxd_level = line_s;
endmodule

// File: rtl/mpx_serial_rx_chk.sv
module mpx_serial_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_en,
   input logic              idwait_set,
   input logic              dready_clr,
   input logic              idwait,
   input logic              dready,
   input logic              ovr,
   input logic              ferr,
   input logic [DATA_W-1:0] rdata
);
   // R6
   overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> ($stable(rdata) && $past(dready)));

   // R7
   ferr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ferr) |-> ($stable(rdata) && !$rose(dready)));

   // R4
   id_clears_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dready) && $past(idwait) && !$past(idwait_set)) |-> !idwait);

   // R8
   error_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr || ferr) |=> !$rose(dready));

   // R11
   disabled_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !$rose(dready));

   // R9
   dready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dready_clr && dready) |=> !dready);
endmodule

bind mpx_serial_rx mpx_serial_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .idwait_set(idwait_set),
   .dready_clr(dready_clr), .idwait(idwait), .dready(dready),
   .ovr(ovr), .ferr(ferr), .rdata(rdata)
);

// File: tb/mpx_serial_rx_tb.sv
`timescale 1ns/1ps
module mpx_serial_rx_tb;
   localparam int CLK_DIV = 4;
   localparam int OVS     = 16;
   localparam int BIT     = CLK_DIV * OVS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rxd = 1'b1, rx_en = 1'b0, idwait_set = 1'b0;
   logic dready_clr = 1'b0, ovr_clr = 1'b0, ferr_clr = 1'b0;
   logic rxd_level, idwait, dready, ovr, ferr;
   logic [7:0] rdata;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   mpx_serial_rx #(.CLK_DIV(CLK_DIV), .OVS(OVS), .DATA_W(8), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en), .idwait_set(idwait_set),
      .dready_clr(dready_clr), .ovr_clr(ovr_clr), .ferr_clr(ferr_clr),
      .rxd_level(rxd_level), .idwait(idwait), .dready(dready), .ovr(ovr),
      .ferr(ferr), .rdata(rdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put_bit(input logic b, input int len);
      rxd = b;
      repeat (len) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input logic mark, input logic stopv);
      put_bit(1'b0, BIT);
      for (int i = 0; i < 8; i++) put_bit(d[i], BIT);
      put_bit(mark, BIT);
      put_bit(stopv, BIT);
      put_bit(1'b1, BIT);
   endtask

   task automatic pulse_dready_clr;
      dready_clr = 1'b1; @(negedge clk); dready_clr = 1'b0; @(negedge clk);
   endtask
   task automatic pulse_ovr_clr;
      ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
   endtask
   task automatic pulse_ferr_clr;
      ferr_clr = 1'b1; @(negedge clk); ferr_clr = 1'b0; @(negedge clk);
   endtask
   task automatic pulse_idwait_set;
      idwait_set = 1'b1; @(negedge clk); idwait_set = 1'b0; @(negedge clk);
   endtask

   task automatic t_reset;
      check("R12 rdata", rdata, 0);
      check("R12 flags", {idwait, dready, ovr, ferr}, 4'b0000);
      check("R10 idle level", rxd_level, 1);
   endtask

   task automatic t_basic;
      // R10: two-edge latency while the receiver is disabled
      rxd = 1'b0; @(negedge clk);
      check("R10 one edge", rxd_level, 1);
      @(negedge clk);
      check("R10 two edges", rxd_level, 0);
      rxd = 1'b1; repeat (4) @(negedge clk);
      check("R11 disabled no frame", dready, 0);
      rx_en = 1'b1; repeat (4) @(negedge clk);
      send(8'hA5, 1'b0, 1'b1);
      check("R1 dready", dready, 1);
      check("R1 rdata A5", rdata, 8'hA5);
      pulse_dready_clr;
      check("R9 dready cleared", dready, 0);
      send(8'h3C, 1'b1, 1'b1);
      check("R1 rdata 3C lsb first", rdata, 8'h3C);
      check("R5 id frame accepted without wait", dready, 1);
      pulse_dready_clr;
   endtask

   task automatic t_glitch;
      put_bit(1'b0, BIT / 4);
      put_bit(1'b1, 3 * BIT);
      check("R2 glitch ignored", dready, 0);
      send(8'h81, 1'b0, 1'b1);
      check("R2 frame after glitch", rdata, 8'h81);
      pulse_dready_clr;
   endtask

   task automatic t_idwait;
      pulse_idwait_set;
      check("R5 idwait set", idwait, 1);
      send(8'h55, 1'b0, 1'b1);
      check("R3 data dropped rdata", rdata, 8'h81);
      check("R3 data dropped flags", {idwait, dready, ovr, ferr}, 4'b1000);
      send(8'h12, 1'b1, 1'b1);
      check("R4 id rdata", rdata, 8'h12);
      check("R4 id flags", {idwait, dready}, 2'b01);
      // mismatch: rearm wait and clear ready
      pulse_idwait_set;
      pulse_dready_clr;
      send(8'h66, 1'b0, 1'b1);
      check("R3 dropped after rearm", dready, 0);
      send(8'h21, 1'b1, 1'b1);
      check("R4 second id", rdata, 8'h21);
      check("R4 wait cleared", idwait, 0);
      pulse_dready_clr;
      send(8'h77, 1'b0, 1'b1);
      check("R5 data accepted after match", rdata, 8'h77);
      pulse_dready_clr;
   endtask

   task automatic t_overrun;
      send(8'hC3, 1'b0, 1'b1);
      send(8'h5A, 1'b0, 1'b1);
      check("R6 ovr set", ovr, 1);
      check("R6 rdata kept", rdata, 8'hC3);
      pulse_dready_clr;
      send(8'h99, 1'b0, 1'b1);
      check("R8 blocked by ovr", {dready, rdata}, {1'b0, 8'hC3});
      pulse_ovr_clr;
      check("R9 ovr cleared", ovr, 0);
      send(8'h4E, 1'b0, 1'b1);
      check("R8 resumes after ovr", {dready, rdata}, {1'b1, 8'h4E});
      pulse_dready_clr;
   endtask

   task automatic t_framing;
      send(8'hF0, 1'b0, 1'b0);
      check("R7 ferr set", ferr, 1);
      check("R7 data kept", {dready, rdata}, {1'b0, 8'h4E});
      rxd = 1'b0; repeat (3 * BIT) @(negedge clk);
      check("R10 break visible", rxd_level, 0);
      rxd = 1'b1; repeat (BIT) @(negedge clk);
      send(8'h0F, 1'b0, 1'b1);
      check("R8 blocked by ferr", dready, 0);
      pulse_ferr_clr;
      check("R9 ferr cleared", ferr, 0);
      send(8'h0F, 1'b0, 1'b1);
      check("R8 resumes after ferr", {dready, rdata}, {1'b1, 8'h0F});
      pulse_dready_clr;
   endtask

   task automatic t_enable;
      put_bit(1'b0, BIT);
      put_bit(1'b1, 2 * BIT);
      rx_en = 1'b0;
      put_bit(1'b0, 4 * BIT);
      put_bit(1'b1, 3 * BIT);
      check("R11 aborted frame", {dready, ferr, rdata}, {1'b0, 1'b0, 8'h0F});
      rx_en = 1'b1; repeat (4) @(negedge clk);
      send(8'hB7, 1'b0, 1'b1);
      check("R11 receives after enable", rdata, 8'hB7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset;
      t_basic;
      t_glitch;
      t_idwait;
      t_overrun;
      t_framing;
      t_enable;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule